// File: doc/BRIEF.md
# Exception Capture and Return Unit

This unit keeps the exception state of a 32-bit processor and picks the program counter for the next instruction. When the datapath raises an exception, the unit does two things. It saves the address of the faulting instruction in a dedicated saved-PC register, which is separate from the general return-address register. It also writes a code for the reason into a cause register. In the same cycle it steers the next PC to a fixed handler vector, 0x80000180. A return-from-exception strobe steers the next PC back to the saved address.

The fetch stage has already added 4 to the program counter it presents. For that reason the saved address is the presented PC minus 4. The two registers have separate write enables, which the unit drives internally from the exception signal. A one-bit cause selector chooses the code that is written.

Every pin is a plain control or data level that is sampled on each rising clock edge. There is no handshake. The next-PC output is combinational from the inputs and from the saved register, so there is no back-pressure to honour.

Top module: `trap_redirect_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, the saved-PC register and the cause register both read 0 until the first exception.
- R2: With trap_req and eret_req both low, pc_next equals seq_pc in the same cycle.
- R3: With trap_req high, pc_next equals 0x80000180 in the same cycle, whatever seq_pc is.
- R4: A clock edge with trap_req high loads the saved-PC register with cur_pc minus 4, modulo 2^32. For example, cur_pc = 0 gives 0xFFFFFFFC.
- R5: A clock edge with trap_req high loads the cause register with the code picked by trap_kind. trap_kind = 0 (undefined instruction) writes code 0 and trap_kind = 1 (arithmetic overflow) writes code 1. The code sits in bit 0 and bits 31:1 are 0.
- R6: With eret_req high and trap_req low, pc_next equals the current saved-PC register value in the same cycle.
- R7: When eret_req and trap_req are high in the same cycle, the return is ignored. pc_next is the handler vector, and the registers change only as R4 and R5 say.
- R8: A clock edge with trap_req low leaves both registers unchanged. This includes cycles with eret_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pc | input | 32 | Program counter as presented, already advanced by 4 |
| seq_pc | input | 32 | Normal next PC from the sequencing logic |
| trap_req | input | 1 | An exception is raised this cycle |
| trap_kind | input | 1 | Cause selector: 0 undefined instruction, 1 overflow |
| eret_req | input | 1 | Return-from-exception strobe |
| pc_next | output | 32 | Selected next PC |
| epc_q | output | 32 | Saved-PC register |
| cause_q | output | 32 | Cause register |

## Verification
The assertions assume that every input is a defined level at each rising edge, and that trap_kind is relevant only while trap_req is high. They make no other assumption: trap_req and eret_req may be high together, and cur_pc may take any value, including 0. The stimulus changes inputs only on falling edges and draws them from a seeded generator, so both strobes and the collision case appear often. Directed steps add the wrap-around PC, the collision case, and a return issued right after an exception.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned KIND_W     = 1;
  localparam int unsigned PC_STEP    = 4;
  localparam logic [XLEN-1:0] TRAP_VECTOR = 32'h8000_0180;

  typedef enum logic [KIND_W-1:0] {
    KIND_UNDEF_INSN = 1'b0,
    KIND_OVERFLOW   = 1'b1
  } trap_kind_e;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_VECTOR = 2'd1,
    SRC_SAVED  = 2'd2
  } pc_src_e;
endpackage

// File: rtl/trap_cause_enc.sv
module trap_cause_enc
  import trap_pkg::*;
#(
  parameter int unsigned W      = XLEN,
  parameter int unsigned SEL_W  = KIND_W
) (
  input  logic [SEL_W-1:0] kind,
  output logic [W-1:0]     code
);
  localparam int unsigned PAD = W - SEL_W;

  generate
    if (PAD > 0) begin : g_pad
      assign code = {{PAD{1'b0}}, kind};
    end else begin : g_nopad
      assign code = kind[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_pkg::*;
#(
  parameter int unsigned W    = XLEN,
  parameter int unsigned STEP = PC_STEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         epc_we,
  input  logic         cause_we,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] epc,
  output logic [W-1:0] cause
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] fault_pc;
  assign fault_pc = pc_in - STEP_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc <= '0;
    end else if (epc_we) begin
      epc <= fault_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
    end else if (cause_we) begin
      cause <= code_in;
    end
  end

  // R8
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!epc_we && !cause_we) |=> ($stable(epc) && $stable(cause)));
endmodule

// File: rtl/trap_pc_mux.sv
module trap_pc_mux
  import trap_pkg::*;
#(
  parameter int unsigned W = XLEN,
  parameter logic [W-1:0] VECTOR = TRAP_VECTOR
) (
  input  pc_src_e      src,
  input  logic [W-1:0] seq_pc,
  input  logic [W-1:0] saved_pc,
  output logic [W-1:0] pc_out
);
  always_comb begin
    unique case (src)
      SRC_VECTOR: pc_out = VECTOR;
      SRC_SAVED:  pc_out = saved_pc;
      default:    pc_out = seq_pc;
    endcase
  end
endmodule

// File: rtl/trap_redirect_unit.sv
module trap_redirect_unit
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] seq_pc,
  input  logic            trap_req,
  input  logic [KIND_W-1:0] trap_kind,
  input  logic            eret_req,
  output logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] cause_q
);
  pc_src_e         src;
  logic            epc_we;
  logic            cause_we;
  logic [XLEN-1:0] code;

  // exception outranks return, return outranks sequential
  always_comb begin
    if (trap_req)      src = SRC_VECTOR;
    else if (eret_req) src = SRC_SAVED;
    else               src = SRC_SEQ;
  end

  assign epc_we   = trap_req;
  assign cause_we = trap_req;

  trap_cause_enc #(.W(XLEN), .SEL_W(KIND_W)) u_enc (
    .kind (trap_kind),
    .code (code)
  );

  trap_state_regs #(.W(XLEN), .STEP(PC_STEP)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .epc_we   (epc_we),
    .cause_we (cause_we),
    .pc_in    (cur_pc),
    .code_in  (code),
    .epc      (epc_q),
    .cause    (cause_q)
  );

  trap_pc_mux #(.W(XLEN), .VECTOR(TRAP_VECTOR)) u_mux (
    .src      (src),
    .seq_pc   (seq_pc),
    .saved_pc (epc_q),
    .pc_out   (pc_next)
  );

  // R3
  vector_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (pc_next == TRAP_VECTOR));

  // R4
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (epc_q == $past(cur_pc) - XLEN'(PC_STEP)));

  // R5
  cause_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (cause_q == XLEN'($past(trap_kind))));

  // R6
  return_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && !trap_req) |-> (pc_next == epc_q));

  // R2
  seq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eret_req && !trap_req) |-> (pc_next == seq_pc));
endmodule

// File: tb/trap_redirect_unit_bench.sv
`timescale 1ns/1ps
module trap_redirect_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [31:0] seq_pc = '0;
  logic        trap_req = 1'b0;
  logic [0:0]  trap_kind = '0;
  logic        eret_req = 1'b0;
  logic [31:0] pc_next, epc_q, cause_q;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_epc = '0;
  logic [31:0] m_cause = '0;
  int unsigned seed = 32'd2024;

  always #10 clk = ~clk;

  trap_redirect_unit u_trap_redirect_unit (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .seq_pc(seq_pc),
    .trap_req(trap_req), .trap_kind(trap_kind), .eret_req(eret_req),
    .pc_next(pc_next), .epc_q(epc_q), .cause_q(cause_q)
  );

  function automatic logic [31:0] exp_next(logic t, logic r, logic [31:0] s,
                                           logic [31:0] e);
    if (t) return 32'h8000_0180;
    if (r) return e;
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, check comb output, then take the rising edge
  task automatic step(logic t, logic k, logic r, logic [31:0] cp,
                      logic [31:0] sp, string req);
    @(negedge clk);
    trap_req = t; trap_kind = k; eret_req = r; cur_pc = cp; seq_pc = sp;
    #1;
    check(req, pc_next, exp_next(t, r, sp, m_epc));
    @(posedge clk);
    if (t) begin
      m_epc = cp - 32'd4;
      m_cause = {31'b0, k};
    end
    @(negedge clk);
    check("R4/R8 epc", epc_q, m_epc);
    check("R5/R8 cause", cause_q, m_cause);
  endtask

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 epc in reset", epc_q, 32'h0);
    check("R1 cause in reset", cause_q, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 epc after reset", epc_q, 32'h0);
    check("R1 cause after reset", cause_q, 32'h0);

    step(1'b0, 1'b0, 1'b0, 32'h0000_0104, 32'h0000_0108, "R2 seq");
    step(1'b0, 1'b0, 1'b1, 32'h0000_0104, 32'h0000_0108, "R6 return of zero");
    step(1'b1, 1'b1, 1'b0, 32'h0040_0020, 32'h0040_0024, "R3 overflow trap");
    step(1'b0, 1'b0, 1'b1, 32'h8000_0184, 32'h8000_0188, "R6 return after trap");
    step(1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0004, "R3 undef trap wrap");
    check("R4 wrap", epc_q, 32'hFFFF_FFFC);
    step(1'b1, 1'b1, 1'b1, 32'h1234_5678, 32'h1234_567C, "R7 collision");
    check("R7 epc", epc_q, 32'h1234_5674);
    check("R7 cause", cause_q, 32'h1);
    step(1'b0, 1'b0, 1'b1, 32'h0, 32'h0, "R8 return keeps regs");

    for (int i = 0; i < 3000; i++) begin
      logic t, k, r;
      logic [31:0] cp, sp;
      t  = ($urandom(seed) % 4) == 0;
      seed = seed + 32'd7919;
      k  = $urandom(seed) % 2;
      seed = seed + 32'd104729;
      r  = ($urandom(seed) % 3) == 0;
      seed = seed + 32'd1299709;
      cp = $urandom(seed);
      seed = seed + 32'd15485863;
      sp = $urandom(seed);
      seed = seed + 32'd32452843;
      step(t, k, r, cp, sp, "R2/R3/R6/R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule